// File: doc/BRIEF.md
# Saturating Half-Precision to 16-bit Integer Converter

This block takes an IEEE 754 binary16 operand and turns it into a 16-bit integer. A mode input chooses a two's-complement signed result or an unsigned result. The fraction is always truncated toward zero. Values that do not fit the chosen range clamp to the nearest limit. Every NaN gives zero.

A combinational control stage splits the operand into its fields and classifies it: NaN, infinity, zero or subnormal, or normal. It then sends a small set of strobes to the datapath. The datapath aligns the significand to integer position, negates it for signed results, and applies the clamps. An optional output register, selected by a parameter, adds one cycle of latency and holds the last result between valid inputs.

Top module: `fp16_to_int16_sat`

## Requirements
- R1: Fractional magnitude is discarded toward zero in both modes: 2.75 (0x4180) gives 2, 1.999 (0x3FFF) gives 1, and -2.75 (0xC180) gives 0xFFFE in signed mode.
- R2: In signed mode (signedMode=1), a positive finite value above 32767 gives 0x7FFF. For example, 32768 (0x7800) and 65504 (0x7BFF) both give 0x7FFF.
- R3: In signed mode, a negative value whose truncated magnitude exceeds 32768 gives 0x8000 (e.g. -65504, 0xFBFF). Exactly -32768 (0xF800) also gives 0x8000.
- R4: Positive infinity (0x7C00) gives 0x7FFF in signed mode and 0xFFFF in unsigned mode (signedMode=0).
- R5: Any NaN gives 0 in both modes. A NaN is an exponent field of all ones with a nonzero mantissa, of either sign, quiet or signaling (e.g. 0x7E00, 0x7C01, 0xFE00).
- R6: In unsigned mode, every negative input gives 0. This covers negative finite values and negative infinity (0xFC00).
- R7: Zeros of either sign and subnormals (exponent field 0) give 0 in both modes.
- R8: In signed mode, negative infinity (0xFC00) gives 0x8000.
- R9: In-range normal values convert exactly. Examples: 1.0 (0x3C00) gives 1; 100 (0x5640) gives 0x0064; -100 (0xD640) gives 0xFF9C signed; 32752 (0x77FF) gives 0x7FF0 signed; 65504 gives 0xFFE0 unsigned.
- R10: With the output register enabled, validOut equals validIn delayed by one cycle. resultOut changes only in the cycle after validIn was high, so it holds while validOut is low.
- R11: After reset, validOut is 0 and resultOut is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Operand and mode are valid this cycle |
| opIn | input | 16 | binary16 operand: bit 15 sign, bits 14:10 exponent, bits 9:0 mantissa |
| signedMode | input | 1 | 1 selects a signed result, 0 selects an unsigned result |
| validOut | output | 1 | Result is valid |
| resultOut | output | 16 | Converted integer |

## Verification
The bench targets the edges of the ranges:
- Exactly -32768 and the nearest positive values on either side of 32767. A converter that clamps with the wrong comparison returns 0x7FFF for -32768, or wraps 32768 to a negative number.
- Negative fractions in both modes. An implementation that rounds instead of truncating returns -3 for -2.75. One that negates in unsigned mode returns large wrapped values instead of zero.
- NaN patterns next to the infinity encodings. A design that tests only the exponent field would saturate those NaNs instead of zeroing them.
- The output-hold checks. They catch a register that reloads on every clock instead of only on valid input.

// File: rtl/fp16cvt_pkg.sv
package fp16cvt_pkg;
  localparam int EXP_W  = 5;
  localparam int MAN_W  = 10;
  localparam int HALF_W = 1 + EXP_W + MAN_W;
  localparam int INT_W  = 16;
  localparam int SIG_W  = MAN_W + 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int PIVOT  = BIAS + MAN_W;
  localparam int MAG_W  = BIAS + 2;

  typedef struct packed {
    logic             zeroOut;
    logic             infPos;
    logic             infNeg;
    logic             negIn;
    logic             signedSel;
    logic [EXP_W-1:0] expField;
    logic [SIG_W-1:0] sig;
  } cvtStrobe_t;
endpackage

// File: rtl/fp16cvt_ctrl.sv
module fp16cvt_ctrl
  import fp16cvt_pkg::*;
(
  input  logic [HALF_W-1:0] opIn,
  input  logic              signedMode,
  output cvtStrobe_t        strb
);
  logic             signBit;
  logic [EXP_W-1:0] expField;
  logic [MAN_W-1:0] manField;
  logic             expAllOnes;
  logic             expZero;
  logic             isNan;
  logic             isInf;

  assign signBit    = opIn[HALF_W-1];
  assign expField   = opIn[HALF_W-2 -: EXP_W];
  assign manField   = opIn[MAN_W-1:0];
  assign expAllOnes = &expField;
  assign expZero    = ~|expField;
  assign isNan      = expAllOnes & (|manField);
  assign isInf      = expAllOnes & ~(|manField);

  always_comb begin
    strb.zeroOut   = isNan | expZero | (~signedMode & signBit);
    strb.infPos    = isInf & ~signBit;
    strb.infNeg    = isInf & signBit & signedMode;
    strb.negIn     = signBit;
    strb.signedSel = signedMode;
    strb.expField  = expField;
    strb.sig       = {1'b1, manField};
  end
endmodule

// File: rtl/fp16cvt_dp.sv
module fp16cvt_dp
  import fp16cvt_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             validIn,
  input  cvtStrobe_t       strb,
  output logic             validOut,
  output logic [INT_W-1:0] resultOut
);
  localparam logic [INT_W-1:0] SAT_POS  = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] SAT_NEG  = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] SAT_UMAX = {INT_W{1'b1}};
  localparam logic [MAG_W-1:0] LIM_POS  = MAG_W'(SAT_POS);
  localparam logic [MAG_W-1:0] LIM_NEG  = MAG_W'(SAT_NEG);
  localparam logic [MAG_W-1:0] LIM_U    = MAG_W'(SAT_UMAX);

  logic [MAG_W-1:0] sigExt;
  logic [MAG_W-1:0] mag;
  logic [MAG_W-1:0] magNeg;
  logic [INT_W-1:0] nextRes;
  int               expVal;

  // align significand to the integer binary point, truncating
  always_comb begin
    sigExt = MAG_W'(strb.sig);
    expVal = int'(strb.expField);
    if (expVal >= PIVOT) mag = sigExt << (expVal - PIVOT);
    else                 mag = sigExt >> (PIVOT - expVal);
    magNeg = ~mag + MAG_W'(1);
  end

  // classification overrides, then range clamp
  always_comb begin
    if (strb.zeroOut)     nextRes = '0;
    else if (strb.infPos) nextRes = strb.signedSel ? SAT_POS : SAT_UMAX;
    else if (strb.infNeg) nextRes = SAT_NEG;
    else if (strb.signedSel) begin
      if (strb.negIn) nextRes = (mag >= LIM_NEG) ? SAT_NEG : magNeg[INT_W-1:0];
      else            nextRes = (mag > LIM_POS) ? SAT_POS : mag[INT_W-1:0];
    end else begin
      nextRes = (mag > LIM_U) ? SAT_UMAX : mag[INT_W-1:0];
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          validOut  <= 1'b0;
          resultOut <= '0;
        end else begin
          validOut <= validIn;
          if (validIn) resultOut <= nextRes;
        end
      end

      a_r10_valid_delay: assert property (@(posedge clk) disable iff (!rstN)
        validIn |=> validOut);
      a_r10_hold_result: assert property (@(posedge clk) disable iff (!rstN)
        !validIn |=> $stable(resultOut));
    end else begin : g_comb
      assign validOut  = validIn;
      assign resultOut = nextRes;
    end
  endgenerate

  a_r5_forced_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.zeroOut |-> nextRes == '0);
  a_r4_pos_inf_max: assert property (@(posedge clk) disable iff (!rstN)
    strb.infPos |-> nextRes == (strb.signedSel ? SAT_POS : SAT_UMAX));
  a_r3_signed_neg_sign: assert property (@(posedge clk) disable iff (!rstN)
    (strb.signedSel && strb.negIn && !strb.zeroOut) |-> (nextRes[INT_W-1] || nextRes == '0));
  a_r2_signed_pos_sign: assert property (@(posedge clk) disable iff (!rstN)
    (strb.signedSel && !strb.negIn && !strb.zeroOut) |-> !nextRes[INT_W-1]);
endmodule

// File: rtl/fp16_to_int16_sat.sv
module fp16_to_int16_sat
  import fp16cvt_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [HALF_W-1:0] opIn,
  input  logic              signedMode,
  output logic              validOut,
  output logic [INT_W-1:0]  resultOut
);
  cvtStrobe_t strb;

  fp16cvt_ctrl u_ctrl (
    .opIn       (opIn),
    .signedMode (signedMode),
    .strb       (strb)
  );

  fp16cvt_dp #(.REG_OUT(REG_OUT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .validIn   (validIn),
    .strb      (strb),
    .validOut  (validOut),
    .resultOut (resultOut)
  );
endmodule

// File: tb/fp16_to_int16_sat_test.sv
module fp16_to_int16_sat_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [15:0] opIn = '0;
  logic        signedMode = 1'b0;
  logic        validOut;
  logic [15:0] resultOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp16_to_int16_sat uut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opIn(opIn),
    .signedMode(signedMode), .validOut(validOut), .resultOut(resultOut)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic convert(input string tag, input logic [15:0] op, input logic mode,
                         input logic [15:0] exp);
    @(negedge clk);
    opIn = op; signedMode = mode; validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
    check({tag, " validOut"}, {15'd0, validOut}, 16'd1);
    check(tag, resultOut, exp);
  endtask

  task automatic test_reset();
    check("R11 reset validOut", {15'd0, validOut}, 16'd0);
    check("R11 reset resultOut", resultOut, 16'd0);
  endtask

  task automatic test_truncation();
    convert("R1 2.75 signed", 16'h4180, 1'b1, 16'h0002);
    convert("R1 2.75 unsigned", 16'h4180, 1'b0, 16'h0002);
    convert("R1 1.999 signed", 16'h3FFF, 1'b1, 16'h0001);
    convert("R1 -2.75 signed", 16'hC180, 1'b1, 16'hFFFE);
    convert("R1 -0.5 signed", 16'hB800, 1'b1, 16'h0000);
    convert("R1 0.5 unsigned", 16'h3800, 1'b0, 16'h0000);
  endtask

  task automatic test_signed_clamp();
    convert("R2 32768 signed", 16'h7800, 1'b1, 16'h7FFF);
    convert("R2 65504 signed", 16'h7BFF, 1'b1, 16'h7FFF);
    convert("R3 -32768 signed", 16'hF800, 1'b1, 16'h8000);
    convert("R3 -65504 signed", 16'hFBFF, 1'b1, 16'h8000);
  endtask

  task automatic test_infinity();
    convert("R4 +inf signed", 16'h7C00, 1'b1, 16'h7FFF);
    convert("R4 +inf unsigned", 16'h7C00, 1'b0, 16'hFFFF);
    convert("R8 -inf signed", 16'hFC00, 1'b1, 16'h8000);
    convert("R6 -inf unsigned", 16'hFC00, 1'b0, 16'h0000);
  endtask

  task automatic test_nan();
    convert("R5 qnan signed", 16'h7E00, 1'b1, 16'h0000);
    convert("R5 snan unsigned", 16'h7C01, 1'b0, 16'h0000);
    convert("R5 neg nan signed", 16'hFE00, 1'b1, 16'h0000);
    convert("R5 neg nan unsigned", 16'hFFFF, 1'b0, 16'h0000);
  endtask

  task automatic test_unsigned_negative();
    convert("R6 -100 unsigned", 16'hD640, 1'b0, 16'h0000);
    convert("R6 -65504 unsigned", 16'hFBFF, 1'b0, 16'h0000);
    convert("R6 -0.5 unsigned", 16'hB800, 1'b0, 16'h0000);
  endtask

  task automatic test_zero_subnormal();
    convert("R7 +0 signed", 16'h0000, 1'b1, 16'h0000);
    convert("R7 -0 unsigned", 16'h8000, 1'b0, 16'h0000);
    convert("R7 min subnormal", 16'h0001, 1'b0, 16'h0000);
    convert("R7 neg subnormal", 16'h83FF, 1'b1, 16'h0000);
  endtask

  task automatic test_exact();
    convert("R9 1.0 signed", 16'h3C00, 1'b1, 16'h0001);
    convert("R9 100 unsigned", 16'h5640, 1'b0, 16'h0064);
    convert("R9 -100 signed", 16'hD640, 1'b1, 16'hFF9C);
    convert("R9 32752 signed", 16'h77FF, 1'b1, 16'h7FF0);
    convert("R9 65504 unsigned", 16'h7BFF, 1'b0, 16'hFFE0);
  endtask

  task automatic test_hold();
    convert("R10 load", 16'h5640, 1'b0, 16'h0064);
    @(negedge clk);
    opIn = 16'h7C00; signedMode = 1'b1;
    @(negedge clk);
    check("R10 validOut low", {15'd0, validOut}, 16'd0);
    check("R10 result held", resultOut, 16'h0064);
    @(negedge clk);
    check("R10 result still held", resultOut, 16'h0064);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_truncation();
    test_signed_clamp();
    test_infinity();
    test_nan();
    test_unsigned_negative();
    test_zero_subnormal();
    test_exact();
    test_hold();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule